// File: doc/BRIEF.md
# Cascaded Real-Time Clock Counter

This block keeps time from the raw oscillator, whatever mode the processor clock is in. It has three counting stages that all count upward. A divide-by-32 front end produces a tick. That tick drives a fixed 8-bit prescaler. Each prescaler wrap advances a 16-bit timer that can be reloaded. Each time that timer wraps, it reloads itself from a programmed value, adds one to a 32-bit long-interval counter and raises a one-clock interrupt request. Taken together, the 16-bit timer and the 32-bit counter form a 48-bit measure of elapsed time.

Software reaches the block through a small 16-bit register port. The port can write the reload value, the timer and either half of the long counter, and it can read all of them back. A read of the low half of the long counter captures the high half at the same moment, so the next read of the high half matches the low half already read. The block has no link to the ordinary system reset. Only a dedicated power-on reset input clears it, so the time it holds survives any reset of the rest of the chip.

Top module: `rtc_chain`

## Requirements
- R1: While `por` is high, every stage, the reload register, the captured high half and `irq` go to zero at each clock edge. No other input clears any state.
- R2: The first stage divides `clk` by 2^DIV_LOG2 (32 by default). Together with the prescaler, the timer advances once every 2^(DIV_LOG2+PRE_W) clocks after `por` falls.
- R3: The prescaler is a fixed up-counter of PRE_W bits (8 by default). Software cannot read it or write it.
- R4: The timer counts up by one on each prescaler wrap.
- R5: When the timer wraps from 0xFFFF, it takes the reload value held before that edge and the long counter adds one. `irq` is then high for exactly the following clock.
- R6: A clock with `rd_en` high and `addr` = 2 captures bits 31:16 of the long counter. Reads with `addr` = 3 return that captured value, not the live counter.
- R7: Writes are decoded on `addr`: 0 sets the reload value, 1 sets the timer, 2 sets counter bits 15:0 and 3 sets counter bits 31:16. A timer write wins over counting in the same clock and gives no wrap. A counter write wins over the increment in the same clock. `rdata` shows, by `addr`, the reload value, the timer, counter bits 15:0, or the captured high half.
- R8: The long counter is 32 bits wide and wraps from 0xFFFFFFFF to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe, used for capture of the high half |
| addr | input | 2 | Register select |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data selected by `addr` |
| irq | output | 1 | Cyclic interrupt request, one clock per timer wrap |

## Verification
The bench steers the timer into back-to-back wraps with reload values close to 0xFFFF. A design that reloaded zero, or used a reload value written in the same clock, would show the wrong timer right after `irq`. The long counter is taken to 0xFFFFFFFF to expose a carry that stops at 16 bits. Random writes land in the clock of a wrap, where the wrong priority would lose the written value or give a spurious interrupt. A low read is followed by high reads after the counter has moved on, so a design that returns the live high half shows the newer value. A power-on reset in mid-run confirms that every register clears.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int REG_W = 16;
    localparam int CNT_W = 32;

    typedef enum logic [1:0] {
        RA_RELOAD = 2'd0,
        RA_TIMER  = 2'd1,
        RA_CNT_LO = 2'd2,
        RA_CNT_HI = 2'd3
    } rtc_addr_e;

    typedef struct packed {
        logic wr_reload;
        logic wr_timer;
        logic wr_lo;
        logic wr_hi;
        logic rd_lo;
    } rtc_acc_t;

    function automatic rtc_acc_t rtc_decode(input logic wr, input logic rd,
                                            input logic [1:0] a);
        rtc_acc_t r;
        r.wr_reload = wr && (rtc_addr_e'(a) == RA_RELOAD);
        r.wr_timer  = wr && (rtc_addr_e'(a) == RA_TIMER);
        r.wr_lo     = wr && (rtc_addr_e'(a) == RA_CNT_LO);
        r.wr_hi     = wr && (rtc_addr_e'(a) == RA_CNT_HI);
        r.rd_lo     = rd && (rtc_addr_e'(a) == RA_CNT_LO);
        return r;
    endfunction

endpackage

// File: rtl/rtc_div_stage.sv
module rtc_div_stage #(
    parameter int W = 8
) (
    input  logic clk,
    input  logic por,
    input  logic en,
    output logic carry
);
    logic [W-1:0] q;

    always_ff @(posedge clk) begin
        if (por)
            q <= '0;
        else if (en)
            q <= q + 1'b1;
    end

    assign carry = en && (q == {W{1'b1}});
endmodule

// File: rtl/rtc_count.sv
module rtc_count
    import rtc_pkg::*;
(
    input  logic             clk,
    input  logic             por,
    input  logic             tick,
    input  rtc_acc_t         acc,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] reload,
    output logic [REG_W-1:0] tmr,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    assign wrap = tick && !acc.wr_timer && (tmr == {REG_W{1'b1}});

    always_ff @(posedge clk) begin
        if (por)
            tmr <= '0;
        else if (acc.wr_timer)
            tmr <= wdata;
        else if (wrap)
            tmr <= reload;
        else if (tick)
            tmr <= tmr + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (por)
            cnt <= '0;
        else if (acc.wr_hi)
            cnt <= {wdata, cnt[REG_W-1:0]};
        else if (acc.wr_lo)
            cnt <= {cnt[CNT_W-1:REG_W], wdata};
        else if (wrap)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rtc_bus.sv
module rtc_bus
    import rtc_pkg::*;
(
    input  logic             clk,
    input  logic             por,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [1:0]       addr,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] tmr,
    input  logic [CNT_W-1:0] cnt,
    output rtc_acc_t         acc,
    output logic [REG_W-1:0] reload,
    output logic [REG_W-1:0] shadow,
    output logic [REG_W-1:0] rdata
);
    assign acc = rtc_decode(wr_en, rd_en, addr);

    always_ff @(posedge clk) begin
        if (por) begin
            reload <= '0;
            shadow <= '0;
        end else begin
            if (acc.wr_reload)
                reload <= wdata;
            if (acc.rd_lo)
                shadow <= cnt[CNT_W-1:REG_W];
        end
    end

    always_comb begin
        case (rtc_addr_e'(addr))
            RA_RELOAD: rdata = reload;
            RA_TIMER:  rdata = tmr;
            RA_CNT_LO: rdata = cnt[REG_W-1:0];
            default:   rdata = shadow;
        endcase
    end
endmodule

// File: rtl/rtc_chain.sv
module rtc_chain
    import rtc_pkg::*;
#(
    parameter int DIV_LOG2 = 5,
    parameter int PRE_W    = 8
) (
    input  logic        clk,
    input  logic        por,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [1:0]  addr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output logic        irq
);
    localparam int NSTG = 2;

    logic [NSTG:0]      tick;
    rtc_acc_t           acc;
    logic [REG_W-1:0]   reload_q;
    logic [REG_W-1:0]   shadow_q;
    logic [REG_W-1:0]   tmr_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               wrap;

    assign tick[0] = 1'b1;

    for (genvar g = 0; g < NSTG; g++) begin : g_div
        rtc_div_stage #(.W(g == 0 ? DIV_LOG2 : PRE_W)) u_stage (
            .clk   (clk),
            .por   (por),
            .en    (tick[g]),
            .carry (tick[g+1])
        );
    end

    rtc_bus u_bus (
        .clk    (clk),
        .por    (por),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .addr   (addr),
        .wdata  (wdata),
        .tmr    (tmr_q),
        .cnt    (cnt_q),
        .acc    (acc),
        .reload (reload_q),
        .shadow (shadow_q),
        .rdata  (rdata)
    );

    rtc_count u_count (
        .clk    (clk),
        .por    (por),
        .tick   (tick[NSTG]),
        .acc    (acc),
        .wdata  (wdata),
        .reload (reload_q),
        .tmr    (tmr_q),
        .cnt    (cnt_q),
        .wrap   (wrap)
    );

    always_ff @(posedge clk) begin
        if (por)
            irq <= 1'b0;
        else
            irq <= wrap;
    end
endmodule

// File: rtl/rtc_chain_chk.sv
module rtc_chain_chk (
    input logic        clk,
    input logic        por,
    input logic        irq,
    input logic        wr_en,
    input logic        rd_en,
    input logic [1:0]  addr,
    input logic [15:0] tmr,
    input logic [15:0] rl,
    input logic [15:0] shadow,
    input logic [31:0] cnt
);
    AST_POR_CLEARS: assert property (@(posedge clk) disable iff (por)
        $fell(por) |-> (tmr == 16'd0 && cnt == 32'd0 && rl == 16'd0 && shadow == 16'd0 && !irq)); // R1

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (por)
        irq |=> !irq); // R5

    AST_RELOAD_ON_WRAP: assert property (@(posedge clk) disable iff (por)
        irq |-> tmr == $past(rl)); // R5

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (por)
        (irq && !$past(wr_en && addr[1])) |-> cnt == $past(cnt) + 32'd1); // R5

    AST_SHADOW_CAPTURE: assert property (@(posedge clk) disable iff (por)
        $past(rd_en && addr == 2'd2 && !por) |-> shadow == $past(cnt[31:16])); // R6
endmodule

bind rtc_chain rtc_chain_chk u_chk (
    .clk    (clk),
    .por    (por),
    .irq    (irq),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .addr   (addr),
    .tmr    (tmr_q),
    .rl     (reload_q),
    .shadow (shadow_q),
    .cnt    (cnt_q)
);

// File: tb/test_rtc_chain.sv
`timescale 1ns/1ps
module test_rtc_chain;
    localparam int DLOG = 2;
    localparam int PW   = 3;
    localparam int DIVN = 1 << DLOG;
    localparam int PN   = 1 << PW;

    logic        clk = 1'b0;
    logic        por = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int          m_div, m_pre;
    logic [15:0] m_tmr, m_rl, m_sh;
    logic [31:0] m_cnt;
    logic        m_irq;

    always #2.5 clk = ~clk;

    rtc_chain #(.DIV_LOG2(DLOG), .PRE_W(PW)) i_rtc_chain (
        .clk(clk), .por(por), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_step();
        bit dc, pc, tl, tc;
        logic [15:0] rl_old;
        logic [31:0] c_old;
        rl_old = m_rl;
        c_old  = m_cnt;
        if (por) begin
            m_div = 0; m_pre = 0; m_tmr = 0; m_rl = 0; m_sh = 0; m_cnt = 0; m_irq = 0;
            return;
        end
        dc = (m_div == DIVN - 1);
        m_div = (m_div + 1) % DIVN;
        pc = dc && (m_pre == PN - 1);
        if (dc) m_pre = (m_pre + 1) % PN;
        tl = wr_en && addr == 2'd1;
        tc = pc && !tl && m_tmr == 16'hFFFF;
        if (tl) m_tmr = wdata;
        else if (tc) m_tmr = rl_old;
        else if (pc) m_tmr = m_tmr + 16'd1;
        if (wr_en && addr == 2'd3) m_cnt = {wdata, c_old[15:0]};
        else if (wr_en && addr == 2'd2) m_cnt = {c_old[31:16], wdata};
        else if (tc) m_cnt = c_old + 32'd1;
        m_irq = tc;
        if (wr_en && addr == 2'd0) m_rl = wdata;
        if (rd_en && addr == 2'd2) m_sh = c_old[31:16];
    endtask

    task automatic compare();
        logic [15:0] e;
        string req;
        case (addr)
            2'd0: begin e = m_rl;         req = "R7"; end
            2'd1: begin e = m_tmr;        req = "R4"; end
            2'd2: begin e = m_cnt[15:0];  req = "R8"; end
            default: begin e = m_sh;      req = "R6"; end
        endcase
        check(rdata === e, req, rdata, e);
        check(irq === m_irq, "R5", irq, m_irq);
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
        model_step();
        compare();
    endtask

    task automatic drive(input logic w, input logic r, input logic [1:0] a, input logic [15:0] d);
        wr_en = w; rd_en = r; addr = a; wdata = d;
        cyc();
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired");
            finish_up();
        end
    end

    initial begin
        int n;
        void'($urandom(32'd7));
        // R1: reset state
        por = 1'b1;
        for (int i = 0; i < 3; i++) cyc();
        for (int a = 0; a < 4; a++) begin
            addr = a[1:0];
            #0.1;
            check(rdata === 16'd0, "R1", rdata, 0);
        end
        check(irq === 1'b0, "R1", irq, 0);

        // R2, R3: first timer step after 2^(DIV+PRE) clocks
        addr = 2'd1;
        por = 1'b0;
        n = 0;
        while (rdata == 16'd0 && n < 200) begin
            cyc();
            n++;
        end
        check(n == DIVN * PN, "R2 R3", n, DIVN * PN);

        for (int i = 0; i < 100; i++) drive(0, 0, 2'd1, 16'd0);

        // R5: reload near the top, timer close to the wrap
        drive(1, 0, 2'd0, 16'hFFFC);
        drive(1, 0, 2'd1, 16'hFFFA);
        for (int i = 0; i < 700; i++) drive(0, 0, 2'd1, 16'd0);

        // R6: capture of the high half
        drive(1, 0, 2'd3, 16'h1234);
        drive(1, 0, 2'd2, 16'hFFFE);
        drive(0, 1, 2'd2, 16'd0);
        for (int i = 0; i < 300; i++) drive(0, 0, 2'd3, 16'd0);
        check(rdata === 16'h1234, "R6", rdata, 16'h1234);

        // R8: long counter wraps to zero
        drive(1, 0, 2'd3, 16'hFFFF);
        drive(1, 0, 2'd2, 16'hFFFF);
        for (int i = 0; i < 400; i++) drive(0, 0, 2'd2, 16'd0);
        drive(0, 1, 2'd2, 16'd0);
        drive(0, 0, 2'd3, 16'd0);
        check(rdata === 16'h0000, "R8", rdata, 0);

        // R7: random accesses, many landing on wraps
        for (int i = 0; i < 4000; i++) begin
            logic [1:0]  a;
            logic [15:0] d;
            logic        w, r;
            a = 2'($urandom_range(0, 3));
            w = ($urandom_range(0, 15) == 0);
            r = ($urandom_range(0, 3) == 0);
            d = 16'($urandom);
            if (a <= 2'd1 && $urandom_range(0, 1) == 1) d = 16'hFFF0 | 16'($urandom_range(0, 15));
            drive(w, r, a, d);
        end

        // R1: power-on reset in mid-run
        por = 1'b1;
        cyc();
        cyc();
        por = 1'b0;
        for (int a = 0; a < 4; a++) begin
            addr = a[1:0];
            #0.1;
            check(rdata === 16'd0, "R1", rdata, 0);
        end
        for (int i = 0; i < 100; i++) drive(0, 0, 2'd1, 16'd0);

        done = 1'b1;
        finish_up();
    end
endmodule